// File: doc/BRIEF.md
# Flash Access Mailbox Command Engine

This block is the device side of a register mailbox that a host uses to move flash contents in and out over a configuration-register bus. The host sees three things through a synchronous dword-addressed read/write port: a sixteen-dword data window, a command register and a status register. An on-chip array stands in for the flash.

To start an operation, the host writes the command register with its request bit set. The engine then decodes the opcode, length and flash address. It copies data between the window and the array one dword at a time, or runs a fixed stub delay for the authenticate and power-cycle commands. When it finishes, it posts a status word that names the command it answers and clears the request bit. The host learns that an operation is complete by polling the command register until bit 0 reads zero. A backdoor write port lets a testbench preload the array.

Top module: `flash_mbox_engine`

## Requirements
- R1: After reset, the command register, the status register and all window dwords read as zero.
- R2: Host offsets 1..16 are window dwords 0..15, offset 17 is the command register and offset 18 is the status register. Any other offset reads zero. Read data appears on `host_rdata` one clock after the address is presented.
- R3: Opcode 0 (flash write, command bits 31:28) copies window dwords 0..L to flash dwords A..A+L. Here L is command bits 27:24 and A is command bits 23:2. The source data is taken from the window after the request bit is seen.
- R4: Opcode 2 (flash read) copies flash dwords A..A+N-1 into window dwords 0..N-1, where N is bits 27:24, or 16 when that field is 0. Window dwords at index N and above keep their values.
- R5: A flash read or write whose last dword would lie at or beyond `FLASH_DWORDS` completes with result code 2 (access error) and moves no data.
- R6: Opcodes 1 (authenticate) and 4 (power cycle) complete with result code 0 no sooner than `AUTH_DELAY` cycles after the request.
- R7: Any opcode other than 0, 1, 2 and 4 completes with result code 3 (generic failure).
- R8: On completion, the engine clears command bit 0 and leaves command bits 31:1 as the host wrote them. It writes status as bit 29 = 1, bits 7:4 = the opcode and bits 3:0 = the result code, with every other bit zero. The status register changes only at completion.
- R9: While command bit 0 is set, host writes to the command register and to the window are ignored. Host writes to the status offset are always ignored.
- R10: Backdoor writes (`bd_we`, `bd_addr`, `bd_wdata`) load the array, and a later flash read returns the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Host dword offset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data for the offset presented one clock earlier |
| bd_we | input | 1 | Backdoor array write strobe |
| bd_addr | input | $clog2(FLASH_DWORDS) | Backdoor array dword address |
| bd_wdata | input | 32 | Backdoor array write data |

## Verification
A register read costs one clock: the bench presents the offset on a falling edge, lets one rising edge load `host_rdata`, and samples on the next falling edge. Command completion takes a variable time. It is two cycles of decode and handshake plus one cycle per written dword, two per read dword, or `AUTH_DELAY` cycles for the stub commands. For that reason the bench polls the command register for bit 0 and only then reads status and the window, so no check depends on an exact completion cycle. The single timing bound it does check is the minimum stub delay: it reads bit 0 as still set a few cycles after issue, and it measures elapsed cycles to completion against `AUTH_DELAY`.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // opcodes in command bits 31:28
  localparam logic [3:0] OP_FWRITE = 4'h0;
  localparam logic [3:0] OP_AUTH   = 4'h1;
  localparam logic [3:0] OP_FREAD  = 4'h2;
  localparam logic [3:0] OP_PCYCLE = 4'h4;

  // result codes in status bits 3:0
  localparam logic [3:0] RC_OK     = 4'h0;
  localparam logic [3:0] RC_ACCESS = 4'h2;
  localparam logic [3:0] RC_FAIL   = 4'h3;

  // host offsets
  localparam logic [4:0] OFS_WIN_LO = 5'd1;
  localparam logic [4:0] OFS_WIN_HI = 5'd16;
  localparam logic [4:0] OFS_CMD    = 5'd17;
  localparam logic [4:0] OFS_STAT   = 5'd18;

  localparam int WIN_DWORDS = 16;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CHECK, SQ_WR, SQ_RD_ISSUE, SQ_RD_CAPT, SQ_WAIT, SQ_DONE
  } seq_state_t;
endpackage

// File: rtl/flash_store.sv
module flash_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata
);
  logic [31:0] mem [DEPTH];

  // engine port has priority; backdoor only used while the engine is idle
  always_ff @(posedge clk) begin
    if (a_we)
      mem[a_addr] <= a_wdata;
    else if (b_we)
      mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
  end
endmodule

// File: rtl/mbox_sequencer.sv
module mbox_sequencer
  import mbox_pkg::*;
#(
  parameter int FLASH_DWORDS = 256,
  parameter int AUTH_DELAY   = 8,
  localparam int AW = $clog2(FLASH_DWORDS),
  localparam int DW = $clog2(AUTH_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [31:2]   cmd_f,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [3:0]    win_idx,
  output logic          win_we,
  output logic          done,
  output logic [3:0]    done_code
);
  seq_state_t    state;
  logic [4:0]    idx, last;
  logic [AW-1:0] base;
  logic [3:0]    code;
  logic [DW-1:0] dly;

  logic [3:0]  op, len;
  logic [4:0]  xfer_cnt;
  logic [22:0] end_addr;
  logic        fits;

  assign op  = cmd_f[31:28];
  assign len = cmd_f[27:24];

  always_comb begin
    if (op == OP_FWRITE)
      xfer_cnt = {1'b0, len} + 5'd1;
    else if (len == 4'd0)
      xfer_cnt = 5'd16;
    else
      xfer_cnt = {1'b0, len};
    end_addr = {1'b0, cmd_f[23:2]} + 23'(xfer_cnt);
    fits     = end_addr <= 23'(FLASH_DWORDS);
  end

  assign ram_addr  = base + AW'(idx);
  assign ram_we    = (state == SQ_WR);
  assign win_we    = (state == SQ_RD_CAPT);
  assign win_idx   = idx[3:0];
  assign done      = (state == SQ_DONE);
  assign done_code = code;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      idx   <= '0;
      last  <= '0;
      base  <= '0;
      code  <= RC_OK;
      dly   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (req) state <= SQ_CHECK;
        SQ_CHECK: begin
          idx  <= '0;
          dly  <= '0;
          base <= cmd_f[AW+1:2];
          last <= xfer_cnt - 5'd1;
          code <= RC_OK;
          case (op)
            OP_FWRITE, OP_FREAD: begin
              if (!fits) begin
                code  <= RC_ACCESS;
                state <= SQ_DONE;
              end else begin
                state <= (op == OP_FWRITE) ? SQ_WR : SQ_RD_ISSUE;
              end
            end
            OP_AUTH, OP_PCYCLE: state <= SQ_WAIT;
            default: begin
              code  <= RC_FAIL;
              state <= SQ_DONE;
            end
          endcase
        end
        SQ_WR: begin
          idx <= idx + 5'd1;
          if (idx == last) state <= SQ_DONE;
        end
        SQ_RD_ISSUE: state <= SQ_RD_CAPT;
        SQ_RD_CAPT: begin
          idx   <= idx + 5'd1;
          state <= (idx == last) ? SQ_DONE : SQ_RD_ISSUE;
        end
        SQ_WAIT: begin
          dly <= dly + DW'(1);
          if (dly == DW'(AUTH_DELAY - 1)) state <= SQ_DONE;
        end
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_mbox_engine.sv
module flash_mbox_engine
  import mbox_pkg::*;
#(
  parameter int FLASH_DWORDS = 256,
  parameter int AUTH_DELAY   = 8,
  localparam int AW = $clog2(FLASH_DWORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    host_addr,
  input  logic          host_we,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [31:0]   bd_wdata
);
  logic [31:0]   win_q [WIN_DWORDS];
  logic [31:0]   cmd_q, stat_q;
  logic          req;
  logic [AW-1:0] ram_addr;
  logic          ram_we, win_we, done;
  logic [3:0]    win_idx, done_code;
  logic [31:0]   ram_rdata;
  logic          host_win_hit;
  logic [3:0]    host_win_idx;

  assign req          = cmd_q[0];
  assign host_win_hit = (host_addr >= OFS_WIN_LO) && (host_addr <= OFS_WIN_HI);
  assign host_win_idx = 4'(host_addr - OFS_WIN_LO);

  mbox_sequencer #(
    .FLASH_DWORDS(FLASH_DWORDS),
    .AUTH_DELAY  (AUTH_DELAY)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .cmd_f    (cmd_q[31:2]),
    .ram_addr (ram_addr),
    .ram_we   (ram_we),
    .win_idx  (win_idx),
    .win_we   (win_we),
    .done     (done),
    .done_code(done_code)
  );

  flash_store #(.DEPTH(FLASH_DWORDS)) store_i (
    .clk    (clk),
    .a_addr (ram_addr),
    .a_we   (ram_we),
    .a_wdata(win_q[win_idx]),
    .a_rdata(ram_rdata),
    .b_we   (bd_we),
    .b_addr (bd_addr),
    .b_wdata(bd_wdata)
  );

  // data window: engine capture wins, host writes only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_DWORDS; i++) win_q[i] <= '0;
    end else if (win_we) begin
      win_q[win_idx] <= ram_rdata;
    end else if (host_we && !req && host_win_hit) begin
      win_q[host_win_idx] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      stat_q <= '0;
    end else begin
      if (done) begin
        cmd_q[0] <= 1'b0;
        stat_q   <= {2'b00, 1'b1, 21'd0, cmd_q[31:28], done_code};
      end else if (host_we && !req && host_addr == OFS_CMD) begin
        cmd_q <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (host_win_hit)
      host_rdata <= win_q[host_win_idx];
    else if (host_addr == OFS_CMD)
      host_rdata <= cmd_q;
    else if (host_addr == OFS_STAT)
      host_rdata <= stat_q;
    else
      host_rdata <= '0;
  end
endmodule

// File: rtl/flash_mbox_checker.sv
module flash_mbox_checker #(
  parameter int AUTH_DELAY = 8
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cmd_q,
  input logic [31:0] stat_q,
  input logic [31:0] win0,
  input logic        host_we,
  input logic [4:0]  host_addr
);
  logic [15:0] busy_cyc;
  logic [3:0]  op;
  logic        op_stub, op_bad;

  assign op      = cmd_q[31:28];
  assign op_stub = (op == 4'h1) || (op == 4'h4);
  assign op_bad  = !(op == 4'h0 || op == 4'h1 || op == 4'h2 || op == 4'h4);

  always_ff @(posedge clk) begin
    if (rst || !cmd_q[0])
      busy_cyc <= '0;
    else if (busy_cyc != 16'hFFFF)
      busy_cyc <= busy_cyc + 16'd1;
  end

  // R9: command fields frozen while busy
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[0] && $past(cmd_q[0])) |-> $stable(cmd_q[31:1]));

  // R9: host write to window dword 0 while busy on a non-read op is dropped
  p_win_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[0] && $past(cmd_q[0]) && $past(host_we) && $past(host_addr) == 5'd1
     && op != 4'h2) |-> $stable(win0));

  // R8: status only changes when the request bit falls
  p_stat_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_q) |-> $fell(cmd_q[0]));

  // R8: status echoes opcode and flags response
  p_stat_echo_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_q[0]) |-> (stat_q[7:4] == $past(cmd_q[31:28]) && stat_q[29]));

  // R6: stub commands complete OK after the delay
  p_stub_ok_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cmd_q[0]) && $past(op_stub)) |-> (stat_q[3:0] == 4'h0));

  p_stub_delay_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cmd_q[0]) && $past(op_stub)) |-> (busy_cyc >= 16'(AUTH_DELAY)));

  // R7: unknown opcodes fail
  p_bad_op_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(cmd_q[0]) && $past(op_bad)) |-> (stat_q[3:0] == 4'h3));

  // R9: status offset not writable
  p_stat_ro_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(host_we) && $past(host_addr) == 5'd18 && !$fell(cmd_q[0])) |-> $stable(stat_q));
endmodule

bind flash_mbox_engine flash_mbox_checker #(.AUTH_DELAY(AUTH_DELAY)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cmd_q    (cmd_q),
  .stat_q   (stat_q),
  .win0     (win_q[0]),
  .host_we  (host_we),
  .host_addr(host_addr)
);

// File: tb/flash_mbox_engine_tb_top.sv
module flash_mbox_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 256;
  localparam int AD = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  host_addr = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        bd_we = 1'b0;
  logic [7:0]  bd_addr = '0;
  logic [31:0] bd_wdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [31:0] flash_m [FL];
  logic [31:0] win_m [16];
  int last_cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_mbox_engine #(.FLASH_DWORDS(FL), .AUTH_DELAY(AD)) dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_win(input int i, input logic [31:0] v);
    host_write(5'(i + 1), v);
    win_m[i] = v;
  endtask

  function automatic logic [3:0] exp_code(input logic [3:0] op, input int addr, input logic [3:0] len);
    int cnt;
    case (op)
      4'h0: begin cnt = int'(len) + 1; return (addr + cnt > FL) ? 4'h2 : 4'h0; end
      4'h2: begin cnt = (len == 0) ? 16 : int'(len); return (addr + cnt > FL) ? 4'h2 : 4'h0; end
      4'h1, 4'h4: return 4'h0;
      default: return 4'h3;
    endcase
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [3:0] op, input logic [3:0] len, input int addr, input bit css);
    return {op, len, 22'(addr), css, 1'b1};
  endfunction

  task automatic wait_done(input string tag, output logic [31:0] v);
    int polls = 0;
    time t0 = $time;
    do begin
      host_read(5'd17, v);
      polls++;
    end while (v[0] && polls < 1000);
    last_cycles = int'(($time - t0) / CLK_PERIOD);
    if (v[0]) check({tag, " completion"}, v & 32'h1, 32'h0);
  endtask

  task automatic do_cmd(input string tag, input logic [3:0] op, input logic [3:0] len, input int addr, input bit css);
    logic [31:0] c, v, s;
    logic [3:0] rc;
    int cnt;
    c  = mk_cmd(op, len, addr, css);
    rc = exp_code(op, addr, len);
    host_write(5'd17, c);
    wait_done(tag, v);
    check({tag, " R8 cmd readback"}, v, c & ~32'h1);
    host_read(5'd18, s);
    check({tag, " R8 status"}, s, {2'b00, 1'b1, 21'd0, op, rc});
    if (rc == 4'h0 && op == 4'h0)
      for (int i = 0; i <= int'(len); i++) flash_m[addr + i] = win_m[i];
    if (rc == 4'h0 && op == 4'h2) begin
      cnt = (len == 0) ? 16 : int'(len);
      for (int i = 0; i < cnt; i++) win_m[i] = flash_m[addr + i];
    end
  endtask

  task automatic check_window(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      host_read(5'(i + 1), v);
      check(tag, v, win_m[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    host_read(5'd17, v); check("R1 cmd after reset", v, 32'h0);
    host_read(5'd18, v); check("R1 status after reset", v, 32'h0);
    host_read(5'd1, v);  check("R1 window after reset", v, 32'h0);
    for (int i = 0; i < 16; i++) win_m[i] = 32'h0;

    // R10 backdoor preload
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      bd_we = 1'b1; bd_addr = 8'(i); bd_wdata = (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
      flash_m[i] = bd_wdata;
    end
    @(negedge clk); bd_we = 1'b0;

    // R2 map
    set_win(0, 32'h1111_0000); set_win(15, 32'hFFFF_000F);
    host_read(5'd1, v);  check("R2 window first", v, 32'h1111_0000);
    host_read(5'd16, v); check("R2 window last", v, 32'hFFFF_000F);
    host_read(5'd0, v);  check("R2 offset 0 reads zero", v, 32'h0);
    host_read(5'd20, v); check("R2 offset 20 reads zero", v, 32'h0);
    host_write(5'd18, 32'hFFFF_FFFF);
    host_read(5'd18, v); check("R9 status write ignored", v, 32'h0);

    // R4 + R10 full read at 0
    do_cmd("R4 full read", 4'h2, 4'h0, 0, 1'b0);
    check_window("R10 R4 full read window");
    // R4 partial read
    do_cmd("R4 partial read", 4'h2, 4'h3, 100, 1'b0);
    check_window("R4 partial read window");
    // R3 write 16 ending exactly at array end
    for (int i = 0; i < 16; i++) set_win(i, 32'hC0DE_0000 + 32'(i));
    do_cmd("R3 write 16 at end", 4'h0, 4'hF, 240, 1'b1);
    do_cmd("R3 readback", 4'h2, 4'h0, 240, 1'b0);
    check_window("R3 readback window");
    // R3 single dword at last address
    set_win(0, 32'h5555_AAAA);
    do_cmd("R3 write 1 at last", 4'h0, 4'h0, 255, 1'b0);
    do_cmd("R3 read 1 at last", 4'h2, 4'h1, 255, 1'b0);
    check_window("R3 single readback");
    // R5 out of range read, window unchanged
    do_cmd("R5 read over end", 4'h2, 4'h0, 241, 1'b0);
    check_window("R5 window untouched");
    // R5 out of range write, flash unchanged
    for (int i = 0; i < 16; i++) set_win(i, 32'hDEAD_0000 + 32'(i));
    do_cmd("R5 write over end", 4'h0, 4'h1, 255, 1'b0);
    do_cmd("R5 flash untouched", 4'h2, 4'h1, 255, 1'b0);
    check_window("R5 flash untouched window");

    // R6 + R9 authenticate with busy writes
    host_write(5'd17, mk_cmd(4'h1, 4'h0, 0, 1'b0));
    host_write(5'd1, 32'hBAD0_BAD0);
    host_write(5'd17, 32'h0);
    host_read(5'd17, v); check("R9 cmd write ignored while busy", v, 32'h1000_0001);
    wait_done("R6 auth", v);
    n_tests++;
    if (last_cycles + 6 < AD) begin
      n_fail++;
      $display("FAIL R6 auth delay actual=%0d expected>=%0d", last_cycles + 6, AD);
    end
    host_read(5'd18, v); check("R6 auth status", v, 32'h2000_0010);
    host_read(5'd1, v);  check("R9 window write ignored while busy", v, win_m[0]);
    do_cmd("R6 power cycle", 4'h4, 4'h0, 0, 1'b0);
    do_cmd("R7 unknown opcode", 4'h7, 4'h2, 5, 1'b0);
    do_cmd("R7 unknown opcode F", 4'hF, 4'h0, 0, 1'b0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int sel, addr;
      logic [3:0] op, len;
      sel  = int'($urandom % 8);
      addr = int'($urandom % 280);
      len  = 4'($urandom);
      if (sel < 3) begin
        op = 4'h0;
        for (int k = 0; k < 4; k++) set_win(int'($urandom % 16), $urandom);
      end else if (sel < 6) op = 4'h2;
      else if (sel == 6) op = ($urandom % 2) ? 4'h1 : 4'h4;
      else begin
        op = 4'($urandom);
        if (op == 4'h0 || op == 4'h1 || op == 4'h2 || op == 4'h4) op = 4'h9;
      end
      do_cmd("R3 R4 R5 R7 random", op, len, addr, 1'($urandom));
      if (op == 4'h2) check_window("R4 random window");
    end
    do_cmd("R3 final sweep", 4'h2, 4'h0, 0, 1'b0);
    check_window("R3 final window");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule